// File: doc/BRIEF.md
# Serial Clock-Calendar Register Slave

This block is a clock-calendar register bank that a host reaches over a four-wire serial link. It keeps seven time-of-day and calendar bytes in packed BCD: seconds, minutes, hours, weekday, day of month, month and two-digit year. Beside them sit two alarm sets of four bytes each, a control byte, a read-only status byte, a plain charger-setting byte and a user RAM area. A once-per-second strobe from outside advances the calendar. Carries ripple through minutes, hours, day, month and year, and month lengths and leap years are taken into account.

The host raises the select line, shifts one command byte, then shifts any number of data bytes. Bit 7 of the command chooses the direction and bits 6:0 give the first register. The register pointer steps after every data byte, so one transaction can fetch or load the whole calendar. A lock bit in the control byte refuses writes to every location except the control byte itself. A second strobe that arrives while the host holds the select line is deferred until the line drops. A multi-byte read therefore never straddles a carry.

Top module: `spi_clock_regs`

## Requirements
- R1: After reset, the control byte (address 0x0F) reads 0x40, seconds/minutes/hours/year (0x00, 0x01, 0x02, 0x06) read 0x00, and weekday/day/month (0x03, 0x04, 0x05) read 0x01.
- R2: A rising select starts a transaction and the first byte is the command: bit 7 = 1 writes and bit 7 = 0 reads, with bits 6:0 as the start address. Bytes travel MSB first. The input data line is taken on the falling serial clock. The output line changes only on a rising serial clock and holds while the clock is high. The output line is 0 while select is low.
- R3: Each data byte after the command goes to or comes from the pointer, which then advances by one. A seven-byte burst from 0x00 loads or returns the whole calendar.
- R4: The pointer goes from 0x1F to 0x00, and from the last RAM address (0x20 + RAM_BYTES - 1, 0x3F by default) to 0x20.
- R5: While control bit 6 is 1, writes to every address except 0x0F are dropped. Writing 0x00 to 0x0F unlocks the block.
- R6: A write keeps only the valid bits of each field: bits 6:0 for seconds, minutes and hours, bits 2:0 for weekday, bits 5:0 for day, bits 4:0 for month and all 8 bits for year.
- R7: On a strobe, seconds step in BCD, and 0x59 becomes 0x00 and steps minutes. Minutes 0x59 become 0x00 and step hours.
- R8: In 24-hour mode (hours bit 6 = 0, bits 5:0 = BCD 00-23), 0x23 becomes 0x00 and steps the day. Weekday steps with the day and wraps from 7 to 1.
- R9: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, bits 4:0 = BCD 01-12), hour 11 becomes 12 and toggles PM, and hour 12 becomes 01 with PM kept. The step from 11 PM to 12 AM steps the day.
- R10: The day wraps to 01 after the month's last day (30 for months 04, 06, 09 and 11; 31 for the other months; 28 for month 02, or 29 when the year is divisible by 4) and steps the month. Month 0x12 becomes 0x01 and steps the year, and year 0x99 becomes 0x00.
- R11: A strobe seen while select is high changes nothing until select falls. Any number of strobes during one transaction apply as a single step.
- R12: The status byte 0x10, addresses 0x12-0x1F and addresses above the RAM read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Active-high transaction select |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| miso | output | 1 | Serial data to the host |

## Verification
Two functions of this block can fall in the same cycle: the seconds strobe and a host transaction on the calendar. The bench raises select, sends a read command, and pulses the strobe twice while select is high. It then reads the seconds inside the same transaction and expects the value from before the strobes. After select drops it reads again and expects exactly one step, not two. A final strobe with select low checks that the deferral does not block later steps.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
// Shared address map and BCD helpers for the clock-calendar register slave.
// Assumes two-digit packed BCD fields throughout.
package scr_pkg;
    localparam int          AW          = 7;
    localparam logic [6:0]  A_YEAR      = 7'h06;
    localparam logic [6:0]  A_ALM_FIRST = 7'h07;
    localparam logic [6:0]  A_ALM_LAST  = 7'h0E;
    localparam logic [6:0]  A_CTRL      = 7'h0F;
    localparam logic [6:0]  A_CHRG      = 7'h11;
    localparam logic [6:0]  A_LOW_TOP   = 7'h1F;
    localparam logic [6:0]  A_RAM_BASE  = 7'h20;
    localparam int          LOCK_BIT    = 6;
    localparam int          ALM_BYTES   = 8;

    // Packed-BCD increment of a two-digit byte without range wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    // Last valid day (BCD) of a BCD month, leap when the BCD year is a multiple of 4.
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic leap;
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        case (mon)
            8'h02:                    return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                  return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/scr_spi_port.sv
`timescale 1ns/1ps
// Serial front end: detects clock edges in the system clock domain,
// assembles command/data bytes MSB first on falling serial clock and
// shifts the supplied read byte out on rising serial clock.
// Assumes each serial half period spans at least three system clocks.
module scr_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       ce_q,
    output logic       ce_rise,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic       sck_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [6:0] tx_sh;
    logic       sck_rise;
    logic       sck_fall;

    assign sck_rise = ce & ~sck_q & sck;
    assign sck_fall = ce & sck_q & ~sck;
    assign ce_rise  = ce & ~ce_q;

    // Keep one-cycle history of select and serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ce_q  <= 1'b0;
        end else begin
            sck_q <= sck;
            ce_q  <= ce;
        end
    end

    // Collect eight input bits and flag each completed byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!ce) begin
                bit_cnt <= '0;
            end else if (sck_fall) begin
                rx_sh   <= {rx_sh[5:0], mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, mosi};
                end
            end
        end
    end

    // Present the next output bit on each rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (!ce) begin
            miso <= 1'b0;
        end else if (sck_rise) begin
            if (bit_cnt == 3'd0) begin
                miso  <= tx_byte[7];
                tx_sh <= tx_byte[6:0];
            end else begin
                miso  <= tx_sh[6];
                tx_sh <= {tx_sh[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/scr_timekeeper.sv
`timescale 1ns/1ps
// Calendar counter: seven BCD bytes advanced by a one-second strobe with
// full carry chain, 12/24-hour handling and leap years. A strobe seen while
// hold is high is remembered and applied once hold drops.
// Assumes writes only arrive while hold is high.
module scr_timekeeper
    import scr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        hold,
    input  logic        we,
    input  logic [2:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        adv,
    output logic [55:0] time_flat
);
    logic [7:0] sec, min, hr, dow, dat, mon, yr;
    logic [7:0] n_sec, n_min, n_hr, n_dow, n_dat, n_mon, n_yr;
    logic       c_min, c_hr, c_day, c_mon, c_yr;
    logic       pend;

    assign adv       = (tick | pend) & ~hold;
    assign time_flat = {yr, mon, dat, dow, hr, min, sec};

    // Compute the calendar one second later.
    always_comb begin
        n_sec = sec; n_min = min; n_hr = hr; n_dow = dow;
        n_dat = dat; n_mon = mon; n_yr = yr;
        c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        c_min = (sec == 8'h59);
        n_sec = c_min ? 8'h00 : bcd_inc(sec);
        c_hr  = c_min && (min == 8'h59);
        if (c_min) n_min = (min == 8'h59) ? 8'h00 : bcd_inc(min);
        if (c_hr) begin
            if (hr[6]) begin
                if (hr[4:0] == 5'h12) begin
                    n_hr = {hr[7:5], 5'h01};
                end else if (hr[4:0] == 5'h11) begin
                    n_hr  = {hr[7:6], ~hr[5], 5'h12};
                    c_day = hr[5];
                end else begin
                    n_hr = bcd_inc(hr);
                end
            end else if (hr[5:0] == 6'h23) begin
                n_hr  = {hr[7:6], 6'h00};
                c_day = 1'b1;
            end else begin
                n_hr = bcd_inc(hr);
            end
        end
        if (c_day) begin
            n_dow = (dow == 8'h07) ? 8'h01 : dow + 8'd1;
            c_mon = (dat == last_day(mon, yr));
            n_dat = c_mon ? 8'h01 : bcd_inc(dat);
        end
        if (c_mon) begin
            c_yr  = (mon == 8'h12);
            n_mon = c_yr ? 8'h01 : bcd_inc(mon);
        end
        if (c_yr) n_yr = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
    end

    // Remember a deferred strobe, then step the calendar or take a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= 8'h00; min <= 8'h00; hr <= 8'h00; dow <= 8'h01;
            dat <= 8'h01; mon <= 8'h01; yr <= 8'h00; pend <= 1'b0;
        end else begin
            pend <= (tick | pend) & hold;
            if (adv) begin
                sec <= n_sec; min <= n_min; hr <= n_hr; dow <= n_dow;
                dat <= n_dat; mon <= n_mon; yr <= n_yr;
            end else if (we) begin
                case (idx)
                    3'd0:    sec <= wdata & 8'h7F;
                    3'd1:    min <= wdata & 8'h7F;
                    3'd2:    hr  <= wdata & 8'h7F;
                    3'd3:    dow <= wdata & 8'h07;
                    3'd4:    dat <= wdata & 8'h3F;
                    3'd5:    mon <= wdata & 8'h1F;
                    default: yr  <= wdata;
                endcase
            end
        end
    end

    // Select the calendar byte addressed by the host.
    always_comb begin
        case (idx)
            3'd0:    rdata = sec;
            3'd1:    rdata = min;
            3'd2:    rdata = hr;
            3'd3:    rdata = dow;
            3'd4:    rdata = dat;
            3'd5:    rdata = mon;
            default: rdata = yr;
        endcase
    end
endmodule

// File: rtl/spi_clock_regs.sv
`timescale 1ns/1ps
// Clock-calendar register slave: serial command decode, auto-stepping
// pointer with two wrap regions, write lock, alarm/control/user storage,
// and the calendar counter.
// Assumes the serial lines are already synchronous to clk.
module spi_clock_regs
    import scr_pkg::*;
#(
    parameter int RAM_BYTES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sck,
    input  logic mosi,
    input  logic tick_1hz,
    output logic miso
);
    localparam int         RAM_AW  = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam logic [6:0] RAM_TOP = 7'(int'(A_RAM_BASE) + RAM_BYTES - 1);

    logic        ce_q, ce_rise, rx_valid;
    logic [7:0]  rx_byte, tx_byte, tk_rdata;
    logic        addr_phase, wr_mode;
    logic [6:0]  ptr_q, alm_off, ram_off;
    logic [7:0]  ctrl_q, chrg_q;
    logic [7:0]  alarm_q [ALM_BYTES];
    logic [7:0]  ram_q   [RAM_BYTES];
    logic        wr_ok, time_we, ram_hit, tk_adv;
    logic [55:0] time_flat;

    // Step the pointer, folding back at the end of each region.
    function automatic logic [6:0] step_ptr(input logic [6:0] p);
        if (p == A_LOW_TOP) return 7'h00;
        if (p == RAM_TOP)   return A_RAM_BASE;
        return p + 7'd1;
    endfunction

    assign alm_off = ptr_q - A_ALM_FIRST;
    assign ram_off = ptr_q - A_RAM_BASE;
    assign ram_hit = (ptr_q >= A_RAM_BASE) && (ptr_q <= RAM_TOP);
    assign wr_ok   = rx_valid & ~addr_phase & wr_mode
                   & ((ptr_q == A_CTRL) | ~ctrl_q[LOCK_BIT]);
    assign time_we = wr_ok & (ptr_q <= A_YEAR);

    scr_spi_port u_port (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .mosi(mosi),
        .tx_byte(tx_byte), .ce_q(ce_q), .ce_rise(ce_rise),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso)
    );

    scr_timekeeper u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold(ce | ce_q),
        .we(time_we), .idx(ptr_q[2:0]), .wdata(rx_byte),
        .rdata(tk_rdata), .adv(tk_adv), .time_flat(time_flat)
    );

    // Track command byte, direction and pointer within a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_phase <= 1'b0;
            wr_mode    <= 1'b0;
            ptr_q      <= '0;
        end else if (ce_rise) begin
            addr_phase <= 1'b1;
        end else if (rx_valid) begin
            if (addr_phase) begin
                ptr_q      <= rx_byte[6:0];
                wr_mode    <= rx_byte[7];
                addr_phase <= 1'b0;
            end else begin
                ptr_q <= step_ptr(ptr_q);
            end
        end
    end

    // Store control, charger and alarm bytes on permitted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 8'h40;
            chrg_q <= 8'h00;
            for (int i = 0; i < ALM_BYTES; i++) alarm_q[i] <= 8'h00;
        end else if (wr_ok) begin
            if (ptr_q == A_CTRL) ctrl_q <= rx_byte;
            if (ptr_q == A_CHRG) chrg_q <= rx_byte;
            if (ptr_q >= A_ALM_FIRST && ptr_q <= A_ALM_LAST) alarm_q[alm_off[2:0]] <= rx_byte;
        end
    end

    // Store user RAM bytes on permitted writes (no reset on the array).
    always_ff @(posedge clk) begin
        if (wr_ok && ram_hit) ram_q[ram_off[RAM_AW-1:0]] <= rx_byte;
    end

    // Select the byte at the pointer for the next outgoing byte.
    always_comb begin
        tx_byte = 8'h00;
        if (ptr_q <= A_YEAR)          tx_byte = tk_rdata;
        else if (ptr_q <= A_ALM_LAST) tx_byte = alarm_q[alm_off[2:0]];
        else if (ptr_q == A_CTRL)     tx_byte = ctrl_q;
        else if (ptr_q == A_CHRG)     tx_byte = chrg_q;
        else if (ram_hit)             tx_byte = ram_q[ram_off[RAM_AW-1:0]];
    end
endmodule

// File: rtl/scr_checker.sv
`timescale 1ns/1ps
// Property checker for spi_clock_regs, attached with bind below.
module scr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ce,
    input logic        sck,
    input logic        miso,
    input logic [7:0]  ctrl_q,
    input logic        tk_adv,
    input logic        time_we,
    input logic [55:0] time_flat,
    input logic        rx_valid,
    input logic        ce_rise,
    input logic        addr_phase,
    input logic [6:0]  ptr_q
);
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> !miso); // R2

    AST_MISO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && $past(ce) && $past(ce, 2) && sck && $past(sck) && $past(sck, 2)) |-> $stable(miso)); // R2

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_PTR_LOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ce_rise && !addr_phase && ptr_q == 7'h1F) |=> (ptr_q == 7'h00)); // R4

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[6]) && !$past(tk_adv)) |-> $stable(time_flat)); // R5

    AST_HOLD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && $past(ce) && !$past(time_we)) |-> $stable(time_flat)); // R11
endmodule

bind spi_clock_regs scr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .miso(miso),
    .ctrl_q(ctrl_q), .tk_adv(tk_adv), .time_we(time_we), .time_flat(time_flat),
    .rx_valid(rx_valid), .ce_rise(ce_rise), .addr_phase(addr_phase), .ptr_q(ptr_q)
);

// File: tb/spi_clock_regs_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module spi_clock_regs_test;
    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sck = 1'b0, mosi = 1'b0, tick = 1'b0;
    logic miso;
    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2.5 clk = ~clk;

    spi_clock_regs #(.RAM_BYTES(32)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .mosi(mosi),
        .tick_1hz(tick), .miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(3);
            sck = 1'b1;
            wait_clk(4);
            rx[i] = miso;
            sck = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic begin_xfer();
        ce = 1'b1;
        wait_clk(3);
    endtask

    task automatic end_xfer();
        wait_clk(3);
        ce = 1'b0;
        wait_clk(3);
    endtask

    task automatic wr_regs(input logic [6:0] a, input int n);
        logic [7:0] junk;
        begin_xfer();
        xfer_byte({1'b1, a}, junk);
        for (int i = 0; i < n; i++) xfer_byte(wbuf[i], junk);
        end_xfer();
    endtask

    task automatic rd_regs(input logic [6:0] a, input int n);
        logic [7:0] junk;
        begin_xfer();
        xfer_byte({1'b0, a}, junk);
        for (int i = 0; i < n; i++) xfer_byte(8'h00, rbuf[i]);
        end_xfer();
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        wbuf[0] = d;
        wr_regs(a, 1);
    endtask

    task automatic rd1(input logic [6:0] a, output logic [7:0] d);
        rd_regs(a, 1);
        d = rbuf[0];
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
        wbuf[0] = s; wbuf[1] = m; wbuf[2] = h; wbuf[3] = w;
        wbuf[4] = d; wbuf[5] = mo; wbuf[6] = y;
        wr_regs(7'h00, 7);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        wait_clk(1);
        tick = 1'b0;
        wait_clk(3);
    endtask

    task automatic expect_time(input string tag, input logic [7:0] s, m, h, w, d, mo, y);
        rd_regs(7'h00, 7);
        check8({tag, " sec"},  rbuf[0], s);
        check8({tag, " min"},  rbuf[1], m);
        check8({tag, " hour"}, rbuf[2], h);
        check8({tag, " wday"}, rbuf[3], w);
        check8({tag, " day"},  rbuf[4], d);
        check8({tag, " mon"},  rbuf[5], mo);
        check8({tag, " year"}, rbuf[6], y);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check8("R2 miso idle", {7'd0, miso}, 8'h00);
        expect_time("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        rd1(7'h0F, v);
        check8("R1 control", v, 8'h40);
        check8("R2 miso after", {7'd0, miso}, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        wr1(7'h00, 8'h30);
        rd1(7'h00, v);
        check8("R5 locked sec", v, 8'h00);
        wr1(7'h07, 8'h11);
        rd1(7'h07, v);
        check8("R5 locked alarm", v, 8'h00);
        wr1(7'h0F, 8'h00);
        rd1(7'h0F, v);
        check8("R5 unlock", v, 8'h00);
        wr1(7'h00, 8'h30);
        rd1(7'h00, v);
        check8("R5 unlocked sec", v, 8'h30);
        wr1(7'h07, 8'h11);
        rd1(7'h07, v);
        check8("R5 unlocked alarm", v, 8'h11);
    endtask

    task automatic t_burst();
        set_time(8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        expect_time("R3 burst", 8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    endtask

    task automatic t_mask();
        set_time(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        expect_time("R6 mask", 8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF);
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'hEE; wbuf[1] = 8'h33;
        wr_regs(7'h1F, 2);
        rd_regs(7'h1E, 3);
        check8("R4 0x1E", rbuf[0], 8'h00);
        check8("R4 0x1F", rbuf[1], 8'h00);
        check8("R4 low wrap", rbuf[2], 8'h33);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        wr_regs(7'h3E, 3);
        rd_regs(7'h3E, 3);
        check8("R4 ram 0x3E", rbuf[0], 8'hA1);
        check8("R4 ram 0x3F", rbuf[1], 8'hA2);
        check8("R4 ram wrap", rbuf[2], 8'hA3);
    endtask

    task automatic t_roll();
        set_time(8'h59, 8'h09, 8'h05, 8'h03, 8'h14, 8'h06, 8'h21);
        pulse_tick();
        expect_time("R7 minute carry", 8'h00, 8'h10, 8'h05, 8'h03, 8'h14, 8'h06, 8'h21);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        pulse_tick();
        expect_time("R8 R10 full carry", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_leap();
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        pulse_tick();
        expect_time("R10 leap 28", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        pulse_tick();
        expect_time("R10 leap 29", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23);
        pulse_tick();
        expect_time("R10 common 28", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h23);
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
        pulse_tick();
        expect_time("R10 thirty", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h23);
    endtask

    task automatic t_12h();
        set_time(8'h59, 8'h59, 8'h51, 8'h01, 8'h10, 8'h05, 8'h25);
        pulse_tick();
        expect_time("R9 11am", 8'h00, 8'h00, 8'h72, 8'h01, 8'h10, 8'h05, 8'h25);
        set_time(8'h59, 8'h59, 8'h72, 8'h01, 8'h10, 8'h05, 8'h25);
        pulse_tick();
        expect_time("R9 12pm", 8'h00, 8'h00, 8'h61, 8'h01, 8'h10, 8'h05, 8'h25);
        set_time(8'h59, 8'h59, 8'h71, 8'h01, 8'h10, 8'h05, 8'h25);
        pulse_tick();
        expect_time("R9 11pm", 8'h00, 8'h00, 8'h52, 8'h02, 8'h11, 8'h05, 8'h25);
    endtask

    task automatic t_hold();
        logic [7:0] v, junk;
        set_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h03, 8'h04, 8'h25);
        begin_xfer();
        xfer_byte(8'h00, junk);
        pulse_tick();
        pulse_tick();
        xfer_byte(8'h00, v);
        end_xfer();
        check8("R11 held in transaction", v, 8'h10);
        rd1(7'h00, v);
        check8("R11 single step after", v, 8'h11);
        pulse_tick();
        rd1(7'h00, v);
        check8("R11 later step", v, 8'h12);
    endtask

    task automatic t_status();
        logic [7:0] v;
        wr1(7'h10, 8'h5A);
        rd1(7'h10, v);
        check8("R12 status", v, 8'h00);
        wr1(7'h12, 8'h5A);
        rd1(7'h12, v);
        check8("R12 gap", v, 8'h00);
        wr1(7'h50, 8'h5A);
        rd1(7'h50, v);
        check8("R12 above ram", v, 8'h00);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_protect();
        t_burst();
        t_mask();
        t_wrap();
        t_roll();
        t_leap();
        t_12h();
        t_hold();
        t_status();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule